// File: doc/BRIEF.md
# Dual-Comparator Window Monitor with Interrupt and Event Control

This block sits behind two comparator channels whose filtering is done elsewhere. It takes the two filtered channel states and the per-channel comparison-done pulses, classifies the pair into a three-way window state (above, inside, below), and keeps the interrupt flags, interrupt enables and event routing for both channels and the window. Software sees it through a small byte-addressed register interface. There are separate registers for setting and for clearing the enables, flags that are cleared by writing one, and a status byte.

One level interrupt line is raised whenever any flag is set together with its enable. Three event outputs give one-cycle pulses for channel 0, channel 1 and the window, each gated by its own output-enable bit. Two start-request outputs pass external events through to the channels when the matching event-input bit is set. A self-clearing soft-reset bit in the control byte returns the whole block to its reset state.

Register map (byte addresses): 0 control (bit 0 soft reset, bit 1 window enable, bits 3:2 window condition select), 1 event output enables, 2 event input enables (bits 1:0), 3 enable-clear, 4 enable-set, 5 flags, 6 status. Address 7 reads zero.

Top module: `cmpwin_top`

## Requirements
- R1: After a synchronous reset every register reads zero, `irq` is low and `evt_out` is zero.
- R2: The window state is encoded as 0 = above (channel 1 high), 1 = inside (channel 0 high and channel 1 low), 2 = below (both low). Status (address 6) returns the channel states in bits 1:0 and the window state in bits 5:4.
- R3: While the window enable (control bit 1) is 0, the window state does not change and the window flag is not set.
- R4: The window condition select (control bits 3:2) chooses 0 = above, 1 = inside, 2 = below, 3 = outside (above or below). The window flag is set only in the cycle the updated window state matches the condition and the held state did not.
- R5: Flags, enable-set and enable-clear share one layout: bit 0 channel 0, bit 1 channel 1, bit 4 window. A `ch_done[i]` pulse sets flag bit i.
- R6: Writing 1s to enable-set (address 4) sets those enable bits, and writing 1s to enable-clear (address 3) clears them. Both addresses read back the current enable mask.
- R7: Writing 1 to a flag bit (address 5) clears it, and writing 0 leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R8: `irq` is high exactly when some flag bit and its enable bit are both 1.
- R9: Event output enables sit at address 1 (bit 0 channel 0, bit 1 channel 1, bit 4 window). `evt_out[0]`, `evt_out[1]` and `evt_out[2]` pulse for one cycle, the cycle after the corresponding source fires, only when enabled.
- R10: `start_req[i]` equals `ext_evt[i]` AND event-input enable bit i (address 2, bits 1:0), with no delay.
- R11: Writing control with bit 0 set clears every register, the window state and the event outputs at that clock edge. The soft-reset bit reads 0.
- R12: Reserved register bits ignore writes and read zero, and address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| ch_state | input | 2 | Filtered state of each comparator channel |
| ch_done | input | 2 | Per-channel comparison-done pulse |
| ext_evt | input | 2 | External event inputs |
| irq | output | 1 | Interrupt request |
| evt_out | output | 3 | Event pulses: channel 0, channel 1, window |
| start_req | output | 2 | Channel start requests from external events |

## Verification
The bench targets the edge-detection corner of the window flag. A second outside-region state (below, then above) with the outside condition must not set the flag again. A design that compared against a raw state instead of the held one would raise spurious interrupts. It also drives a set and a clear of the same flag into the same cycle, where a clear-wins design would silently drop an interrupt. It checks that a disabled window keeps its old state while the channels move, since a design that kept tracking would report false status. It issues a soft reset through the register path and expects every register cleared at that same edge. A behavioural reference model compares the interrupt, event, start and read-back outputs on every cycle through a long randomized phase.

// File: rtl/cmpwin_pkg.sv
`timescale 1ns/1ps
package cmpwin_pkg;
    localparam int NCH     = 2;
    localparam int DW      = 8;
    localparam int AW      = 3;
    localparam int WIN_BIT = 4;
    localparam int NSRC    = NCH + 1;

    localparam logic [DW-1:0] SRC_MASK = DW'((1 << NCH) - 1) | DW'(1 << WIN_BIT);

    localparam logic [AW-1:0] A_CTRL   = AW'(0);
    localparam logic [AW-1:0] A_EVOUT  = AW'(1);
    localparam logic [AW-1:0] A_EVIN   = AW'(2);
    localparam logic [AW-1:0] A_IENCLR = AW'(3);
    localparam logic [AW-1:0] A_IENSET = AW'(4);
    localparam logic [AW-1:0] A_FLAG   = AW'(5);
    localparam logic [AW-1:0] A_STAT   = AW'(6);

    localparam int CTRL_SRST = 0;
    localparam int CTRL_WEN  = 1;
    localparam int CTRL_SEL  = 2;

    typedef enum logic [1:0] {
        WS_ABOVE  = 2'd0,
        WS_INSIDE = 2'd1,
        WS_BELOW  = 2'd2
    } wstate_e;

    typedef enum logic [1:0] {
        SEL_ABOVE   = 2'd0,
        SEL_INSIDE  = 2'd1,
        SEL_BELOW   = 2'd2,
        SEL_OUTSIDE = 2'd3
    } wsel_e;

    typedef struct packed {
        wsel_e sel;
        logic  en;
    } win_cfg_t;

    typedef struct packed {
        logic            win;
        logic [NCH-1:0]  ch;
    } src_t;

    // channel 1 is the upper threshold, channel 0 the lower one
    function automatic wstate_e classify(input logic [NCH-1:0] st);
        if (st[1])      return WS_ABOVE;
        else if (st[0]) return WS_INSIDE;
        return WS_BELOW;
    endfunction

    function automatic logic cond_hit(input wsel_e sel, input wstate_e ws);
        case (sel)
            SEL_ABOVE:  return ws == WS_ABOVE;
            SEL_INSIDE: return ws == WS_INSIDE;
            SEL_BELOW:  return ws == WS_BELOW;
            default:    return ws != WS_INSIDE;
        endcase
    endfunction

    function automatic logic [DW-1:0] src_to_byte(input src_t s);
        logic [DW-1:0] b;
        b = '0;
        b[NCH-1:0] = s.ch;
        b[WIN_BIT] = s.win;
        return b;
    endfunction

    function automatic src_t byte_to_src(input logic [DW-1:0] b);
        src_t s;
        s.ch  = b[NCH-1:0];
        s.win = b[WIN_BIT];
        return s;
    endfunction
endpackage

// File: rtl/cmpwin_regs.sv
`timescale 1ns/1ps
module cmpwin_regs
    import cmpwin_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic            srst,
    output win_cfg_t        win_cfg,
    output src_t            evo,
    output logic [NCH-1:0]  evi,
    output src_t            ien,
    output src_t            flag_clr
);
    src_t wsrc;

    assign wsrc     = byte_to_src(wdata);
    assign srst     = we && (addr == A_CTRL) && wdata[CTRL_SRST];
    assign flag_clr = (we && addr == A_FLAG) ? wsrc : '0;

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            win_cfg.en  <= 1'b0;
            win_cfg.sel <= SEL_ABOVE;
            evo         <= '0;
            evi         <= '0;
            ien         <= '0;
        end else if (we) begin
            case (addr)
                A_CTRL: begin
                    win_cfg.en  <= wdata[CTRL_WEN];
                    win_cfg.sel <= wsel_e'(wdata[CTRL_SEL +: 2]);
                end
                A_EVOUT:  evo <= wsrc;
                A_EVIN:   evi <= wdata[NCH-1:0];
                A_IENCLR: ien <= ien & ~wsrc;
                A_IENSET: ien <= ien | wsrc;
                default: ;
            endcase
        end
    end

    assert_ien_set_R6: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_IENSET) |=>
            ((src_to_byte(ien) & $past(wdata)) == ($past(wdata) & SRC_MASK)));

    assert_ien_clr_R6: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_IENCLR) |=>
            ((src_to_byte(ien) & $past(wdata)) == '0));
endmodule

// File: rtl/cmpwin_window.sv
`timescale 1ns/1ps
module cmpwin_window
    import cmpwin_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            srst,
    input  win_cfg_t        cfg,
    input  logic [NCH-1:0]  ch_state,
    output wstate_e         wstate,
    output logic            win_hit
);
    wstate_e ws_new;

    assign ws_new  = classify(ch_state);
    // entry into the condition: the fresh state matches, the held one did not
    assign win_hit = cfg.en && cond_hit(cfg.sel, ws_new) && !cond_hit(cfg.sel, wstate);

    always_ff @(posedge clk) begin
        if (rst || srst)
            wstate <= WS_ABOVE;
        else if (cfg.en)
            wstate <= ws_new;
    end

    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg.en && !srst) |=> $stable(wstate));

    assert_inside_code_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && !srst && ch_state == 2'b01) |=> (wstate == WS_INSIDE));

    assert_below_code_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && !srst && ch_state == 2'b00) |=> (wstate == WS_BELOW));
endmodule

// File: rtl/cmpwin_flags.sv
`timescale 1ns/1ps
module cmpwin_flags
    import cmpwin_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  srst,
    input  src_t  set_src,
    input  src_t  clr_src,
    output src_t  flags
);
    logic [NSRC-1:0] set_v;
    logic [NSRC-1:0] clr_v;
    logic [NSRC-1:0] flag_v;

    assign set_v = set_src;
    assign clr_v = clr_src;

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (rst || srst)
                q <= 1'b0;
            else if (set_v[i])
                q <= 1'b1;
            else if (clr_v[i])
                q <= 1'b0;
        end
        assign flag_v[i] = q;
    end

    assign flags = flag_v;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (!srst && set_v != '0) |=> ((flag_v & $past(set_v)) == $past(set_v)));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
        (!srst && (clr_v & ~set_v) != '0) |=> ((flag_v & $past(clr_v & ~set_v)) == '0));
endmodule

// File: rtl/cmpwin_top.sv
`timescale 1ns/1ps
module cmpwin_top
    import cmpwin_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NCH-1:0]  ch_state,
    input  logic [NCH-1:0]  ch_done,
    input  logic [NCH-1:0]  ext_evt,
    output logic            irq,
    output logic [NSRC-1:0] evt_out,
    output logic [NCH-1:0]  start_req
);
    logic            srst;
    win_cfg_t        win_cfg;
    src_t            evo;
    logic [NCH-1:0]  evi;
    src_t            ien;
    src_t            flag_clr;
    src_t            flags;
    src_t            set_src;
    src_t            evt_q;
    wstate_e         wstate;
    logic            win_hit;

    cmpwin_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .srst     (srst),
        .win_cfg  (win_cfg),
        .evo      (evo),
        .evi      (evi),
        .ien      (ien),
        .flag_clr (flag_clr)
    );

    cmpwin_window u_window (
        .clk      (clk),
        .rst      (rst),
        .srst     (srst),
        .cfg      (win_cfg),
        .ch_state (ch_state),
        .wstate   (wstate),
        .win_hit  (win_hit)
    );

    assign set_src.ch  = ch_done;
    assign set_src.win = win_hit;

    cmpwin_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .srst    (srst),
        .set_src (set_src),
        .clr_src (flag_clr),
        .flags   (flags)
    );

    always_ff @(posedge clk) begin
        if (rst || srst)
            evt_q <= '0;
        else
            evt_q <= set_src & evo;
    end

    assign evt_out   = evt_q;
    assign irq       = |(flags & ien);
    assign start_req = ext_evt & evi;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[CTRL_WEN]       = win_cfg.en;
                bus_rdata[CTRL_SEL +: 2]  = win_cfg.sel;
            end
            A_EVOUT:  bus_rdata = src_to_byte(evo);
            A_EVIN:   bus_rdata[NCH-1:0] = evi;
            A_IENCLR: bus_rdata = src_to_byte(ien);
            A_IENSET: bus_rdata = src_to_byte(ien);
            A_FLAG:   bus_rdata = src_to_byte(flags);
            A_STAT: begin
                bus_rdata[NCH-1:0]           = ch_state;
                bus_rdata[WIN_BIT +: 2]      = wstate;
            end
            default: bus_rdata = '0;
        endcase
    end

    assert_ch0_event_R9: assert property (@(posedge clk) disable iff (rst)
        (ch_done[0] && evo.ch[0] && !srst) |=> evt_out[0]);

    assert_ch1_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (ch_done[1] && !srst) |=> flags.ch[1]);

    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (rst)
        srst |=> (!irq && evt_out == '0 && ien == '0 && flags == '0));
endmodule

// File: tb/sim_cmpwin_top.sv
`timescale 1ns/1ps
module sim_cmpwin_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       bus_we;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [1:0] ch_state;
    logic [1:0] ch_done;
    logic [1:0] ext_evt;
    logic       irq;
    logic [2:0] evt_out;
    logic [1:0] start_req;

    always #10 clk = ~clk;

    cmpwin_top u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ch_state  (ch_state),
        .ch_done   (ch_done),
        .ext_evt   (ext_evt),
        .irq       (irq),
        .evt_out   (evt_out),
        .start_req (start_req)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference state
    int m_en, m_sel, m_eo, m_ei, m_ien, m_flags, m_ws, m_evt;

    function automatic int win_of(input int ch);
        if ((ch & 2) != 0) return 0;
        if ((ch & 1) != 0) return 1;
        return 2;
    endfunction

    function automatic bit win_match(input int sel, input int ws);
        case (sel)
            0: return ws == 0;
            1: return ws == 1;
            2: return ws == 2;
            default: return ws != 1;
        endcase
    endfunction

    function automatic int model_read(input int a);
        case (a)
            0: return (m_sel << 2) | (m_en << 1);
            1: return m_eo;
            2: return m_ei;
            3, 4: return m_ien;
            5: return m_flags;
            6: return int'(ch_state) | (m_ws << 4);
            default: return 0;
        endcase
    endfunction

    task automatic chk(input int got, input int exp, input string tag);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    always @(posedge clk) begin : ref_model
        int wsn;
        int hit;
        int clr;
        int wd;
        if (rst || (bus_we && bus_addr == 3'd0 && bus_wdata[0])) begin
            m_en = 0; m_sel = 0; m_eo = 0; m_ei = 0;
            m_ien = 0; m_flags = 0; m_ws = 0; m_evt = 0;
        end else begin
            wd  = int'(bus_wdata);
            wsn = win_of(int'(ch_state));
            hit = (m_en != 0 && win_match(m_sel, wsn) && !win_match(m_sel, m_ws)) ? 1 : 0;
            clr = (bus_we && bus_addr == 3'd5) ? (wd & 'h13) : 0;
            m_evt = (int'(ch_done) & m_eo & 3) | ((hit != 0 && (m_eo & 'h10) != 0) ? 4 : 0);
            m_flags = (m_flags & ~clr) | int'(ch_done) | (hit << 4);
            if (m_en != 0) m_ws = wsn;
            if (bus_we) begin
                case (bus_addr)
                    3'd0: begin m_en = (wd >> 1) & 1; m_sel = (wd >> 2) & 3; end
                    3'd1: m_eo = wd & 'h13;
                    3'd2: m_ei = wd & 3;
                    3'd3: m_ien = m_ien & ~(wd & 'h13);
                    3'd4: m_ien = m_ien | (wd & 'h13);
                    default: ;
                endcase
            end
        end
    end

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            string rtag;
            chk(int'(irq), ((m_flags & m_ien) != 0) ? 1 : 0, "R8 irq vs model");
            chk(int'(evt_out), m_evt, "R9 evt_out vs model");
            chk(int'(start_req), int'(ext_evt) & m_ei, "R10 start_req vs model");
            case (bus_addr)
                3'd0: rtag = "R11 ctrl readback vs model";
                3'd1, 3'd2: rtag = "R9 event control readback vs model";
                3'd3, 3'd4: rtag = "R6 enable readback vs model";
                3'd5: rtag = "R7 flag readback vs model";
                3'd6: rtag = "R2 status vs model";
                default: rtag = "R12 unmapped read vs model";
            endcase
            chk(int'(bus_rdata), model_read(int'(bus_addr)), rtag);
        end
    end

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick;
        bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
        bus_addr = a;
        @(negedge clk);
        chk(int'(bus_rdata), exp, tag);
        tick;
    endtask

    task automatic out_chk(input int got_sel, input int exp, input string tag);
        @(negedge clk);
        case (got_sel)
            0: chk(int'(irq), exp, tag);
            1: chk(int'(evt_out), exp, tag);
            default: chk(int'(start_req), exp, tag);
        endcase
        tick;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary;
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_we = 1'b0; bus_addr = 3'd0; bus_wdata = 8'h00;
        ch_state = 2'b00; ch_done = 2'b00; ext_evt = 2'b00;
        @(posedge clk); #2;
        repeat (3) tick;
        rst = 1'b0;

        // R1: reset values
        for (int a = 0; a < 6; a++) rd_chk(3'(a), 0, "R1 register reset value");
        out_chk(0, 0, "R1 irq after reset");
        out_chk(1, 0, "R1 evt_out after reset");

        // R12: reserved bits and unmapped address
        wr(3'd0, 8'hF0);
        rd_chk(3'd0, 'h00, "R12 control reserved bits");
        wr(3'd4, 8'hFF);
        rd_chk(3'd4, 'h13, "R12 enable reserved bits");
        rd_chk(3'd7, 'h00, "R12 unmapped address");

        // R6: enable set / clear
        wr(3'd3, 8'h01);
        rd_chk(3'd3, 'h12, "R6 enable-clear readback");
        rd_chk(3'd4, 'h12, "R6 enable-set readback");

        // R5: channel flags
        ch_done = 2'b01; tick; ch_done = 2'b00;
        rd_chk(3'd5, 'h01, "R5 channel 0 flag");
        out_chk(0, 0, "R8 flag without enable");
        ch_done = 2'b10; tick; ch_done = 2'b00;
        rd_chk(3'd5, 'h03, "R5 channel 1 flag");
        out_chk(0, 1, "R8 flag with enable");

        // R7: write-one-to-clear and set priority
        wr(3'd5, 8'h00);
        rd_chk(3'd5, 'h03, "R7 writing zero keeps flags");
        ch_done = 2'b01;
        wr(3'd5, 8'h01);
        ch_done = 2'b00;
        rd_chk(3'd5, 'h03, "R7 set wins over clear");
        wr(3'd5, 8'h03);
        rd_chk(3'd5, 'h00, "R7 clear both flags");
        out_chk(0, 0, "R8 irq drops after clear");

        // R3: window disabled holds its state
        ch_state = 2'b01; tick;
        rd_chk(3'd6, 'h01, "R3 disabled window stays above");
        rd_chk(3'd5, 'h00, "R3 disabled window sets no flag");

        // R4: inside condition, entry
        wr(3'd0, 8'h06);
        tick;
        rd_chk(3'd5, 'h10, "R4 inside entry sets window flag");
        rd_chk(3'd6, 'h11, "R2 inside status code");

        // R3: disable and move channels
        wr(3'd0, 8'h04);
        ch_state = 2'b00; tick;
        rd_chk(3'd6, 'h10, "R3 state held while disabled");

        // R4: outside condition
        wr(3'd5, 8'h10);
        wr(3'd0, 8'h0E);
        tick;
        rd_chk(3'd5, 'h10, "R4 outside entered from inside");
        rd_chk(3'd6, 'h20, "R2 below status code");
        wr(3'd5, 8'h10);
        ch_state = 2'b10; tick; tick;
        rd_chk(3'd5, 'h00, "R4 below to above is no new entry");
        rd_chk(3'd6, 'h02, "R2 above status code");

        // R4: above condition
        wr(3'd0, 8'h02);
        ch_state = 2'b01; tick;
        ch_state = 2'b10; tick; tick;
        rd_chk(3'd5, 'h10, "R4 above entry sets window flag");

        // R9: event outputs
        wr(3'd5, 8'h10);
        wr(3'd1, 8'h13);
        ch_done = 2'b01; tick; ch_done = 2'b00;
        out_chk(1, 1, "R9 channel 0 event pulse");
        out_chk(1, 0, "R9 event lasts one cycle");
        ch_state = 2'b01; tick;
        ch_state = 2'b10; tick;
        out_chk(1, 4, "R9 window event pulse");
        wr(3'd1, 8'h00);
        ch_done = 2'b10; tick; ch_done = 2'b00;
        out_chk(1, 0, "R9 disabled event output");

        // R10: start requests
        wr(3'd2, 8'h03);
        ext_evt = 2'b10;
        out_chk(2, 2, "R10 start request passes");
        wr(3'd2, 8'h01);
        out_chk(2, 0, "R10 start request masked");
        ext_evt = 2'b00;

        // R8: enable window interrupt
        wr(3'd4, 8'h13);
        ch_done = 2'b01; tick; ch_done = 2'b00;
        out_chk(0, 1, "R8 irq raised");

        // R11: soft reset
        wr(3'd0, 8'h01);
        for (int a = 0; a < 6; a++) rd_chk(3'(a), 0, "R11 soft reset clears register");
        rd_chk(3'd6, 'h02, "R11 soft reset clears window state");
        out_chk(0, 0, "R11 irq after soft reset");

        // randomized phase, checked against the model every cycle
        for (int k = 0; k < 600; k++) begin
            ch_state = 2'($urandom_range(0, 3));
            ch_done  = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
            ext_evt  = 2'($urandom_range(0, 3));
            bus_addr = 3'($urandom_range(0, 7));
            bus_we   = ($urandom_range(0, 2) == 0);
            bus_wdata = 8'($urandom_range(0, 255));
            if (bus_addr == 3'd0 && $urandom_range(0, 15) != 0) bus_wdata[0] = 1'b0;
            tick;
        end
        bus_we = 1'b0;
        tick;

        done = 1;
        summary;
        $finish;
    end
endmodule